// File: doc/BRIEF.md
# Split-Tenure System Bus Arbiter

This block is the central arbiter of a shared system bus on which the address phase and the data phase of a transfer have separate owners. Up to four masters each raise a request line. The arbiter answers with an address-phase grant and later, once that address phase has been acknowledged, with a separate data-phase grant. While one master's data is still moving, another master can therefore run its address phase.

The arbiter follows the bus through its control strobes. A transfer-start strobe from the granted master opens an address tenure. The arbiter raises its address-busy indication until an address acknowledge ends that tenure. Acknowledged tenures wait in order for the data bus, and at most two may wait at once. Each one receives the data grant after the previous data tenure has closed with a transfer acknowledge. An address retry cancels the tenure it hits. The retried master then competes for the bus again, and no data grant is ever issued for the cancelled transfer.

Top module: `split_bus_arbiter`

## Requirements
- R1: While reset is low, and on the first cycle after it, every address grant and data grant is 0 and both busy outputs are 0.
- R2: An address grant appears on the cycle after the request is sampled, never in the same cycle. At most one address grant bit is high at a time, and none is high while address-busy is high.
- R3: Among simultaneous requesters the winner is the first one found when counting upward (with wrap) from the index after the last address winner. After reset the last winner counts as the highest index, so master 0 has first priority.
- R4: A transfer-start strobe sampled while a grant is out clears that grant and sets address-busy on the next cycle. Address-busy then stays high until an address acknowledge or retry is sampled, and falls on the cycle after that.
- R5: If the granted master drops its request before it strobes transfer-start, its grant is withdrawn on the next cycle, and arbitration restarts on the following cycle.
- R6: An acknowledged tenure receives its data grant once the data bus is idle, with one cycle of latency and in acknowledge order. The data grant and data-busy stay high until a transfer acknowledge is sampled, and both fall on the next cycle.
- R7: While two acknowledged tenures are waiting for the data bus, no new address grant is issued.
- R8: An address retry during an address tenure ends that tenure with no data grant, even when an address acknowledge arrives in the same cycle. Address-busy falls on the next cycle, and the retried request is granted again through normal arbitration.
- R9: An address retry in the cycle right after an address acknowledge removes that just-acknowledged tenure, so it never receives a data grant, even when the data bus is idle.
- R10: A transfer-start without an outstanding grant, an address acknowledge outside an address tenure, and a transfer acknowledge outside a data tenure are all ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_req | input | NM | Request line per master |
| addr_grant | output | NM | Address-phase grant, one-hot or zero |
| data_grant | output | NM | Data-phase grant, one-hot or zero |
| xfer_start | input | 1 | Transfer-start strobe from the granted master |
| addr_ack | input | 1 | Address acknowledge, ends the address tenure |
| xfer_ack | input | 1 | Transfer acknowledge, ends the data tenure |
| addr_retry | input | 1 | Address retry, cancels the address tenure |
| addr_busy | output | 1 | Address tenure in progress |
| data_busy | output | 1 | Data tenure in progress |

## Verification
The hardest coincidence is a retry landing in the cycle right after an address acknowledge, on the same edge where the data side would pop that acknowledged tenure and grant it the idle data bus. The bench builds this case on purpose: it completes one address tenure with the data bus empty and raises the retry on the next cycle. It then judges the case by the data grant, which must stay at zero for two cycles. A second coincidence puts a retry and an acknowledge in the same cycle. The bench checks that case by draining the data side later and confirming that no extra data grant appears.

// File: rtl/split_bus_arb_pkg.sv
`timescale 1ns/1ps
// Shared types for the split-tenure bus arbiter.
package split_bus_arb_pkg;
    // Address-phase ownership states.
    typedef enum logic [1:0] {
        A_IDLE   = 2'd0,  // no grant out, no tenure
        A_GRANT  = 2'd1,  // grant driven, waiting for transfer-start
        A_TENURE = 2'd2   // address tenure open, waiting for ack or retry
    } addr_state_t;
endpackage

// File: rtl/arb_rr_pick.sv
`timescale 1ns/1ps
// Round-robin selector: the search starts at the index after the previous
// winner and wraps. Purely combinational.
// Assumes NM >= 2 and that last_win < NM.
module arb_rr_pick #(
    parameter int NM  = 4,
    parameter int IDW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic [NM-1:0]  req,
    input  logic [IDW-1:0] last_win,
    output logic           found,
    output logic [IDW-1:0] pick
);
    // Search the requesters in rotated order and keep the first hit.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= NM; k++) begin
            int c;
            c = (int'(last_win) + k) % NM;
            if (!found && req[c]) begin
                found = 1'b1;
                pick  = IDW'(c);
            end
        end
    end
endmodule

// File: rtl/arb_tenure_fifo.sv
`timescale 1ns/1ps
// In-order queue of masters whose address tenures were acknowledged and that
// now wait for the data bus. Besides push and pop it can drop the newest
// entry, which cancels a tenure retried just after its acknowledge.
// Assumes the caller never pushes when full, never pops when empty, and
// never pushes and drops in the same cycle.
module arb_tenure_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 2,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_id,
    input  logic          pop,
    input  logic          drop,
    output logic [W-1:0]  head_id,
    output logic [CW-1:0] count
);
    logic [W-1:0]  slot [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;

    // Wrapping pointer step helpers.
    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction
    function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
        return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
    endfunction

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop)
                rd_ptr <= ptr_inc(rd_ptr);
            if (push)
                wr_ptr <= ptr_inc(wr_ptr);
            else if (drop)
                wr_ptr <= ptr_dec(wr_ptr);
            count <= count + CW'(push) - CW'(pop) - CW'(drop);
        end
    end

    // Entry storage; no reset needed since count qualifies every read.
    always_ff @(posedge clk) begin
        if (push)
            slot[wr_ptr] <= push_id;
    end

    assign head_id = slot[rd_ptr];
endmodule

// File: rtl/split_bus_arbiter.sv
`timescale 1ns/1ps
// Central arbiter for a bus with separate address and data ownership.
// Address side: grant -> transfer-start -> tenure -> ack/retry.
// Data side: acknowledged tenures queue in order (up to QDEPTH) and each
// gets the data grant once the previous data tenure ended with xfer_ack.
// Assumes all inputs are synchronous to clk and that masters hold their
// request until granted.
module split_bus_arbiter #(
    parameter int NM     = 4,
    parameter int QDEPTH = 2,
    localparam int IDW   = (NM > 1) ? $clog2(NM) : 1,
    localparam int CW    = $clog2(QDEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NM-1:0] bus_req,
    output logic [NM-1:0] addr_grant,
    output logic [NM-1:0] data_grant,
    input  logic          xfer_start,
    input  logic          addr_ack,
    input  logic          xfer_ack,
    input  logic          addr_retry,
    output logic          addr_busy,
    output logic          data_busy
);
    import split_bus_arb_pkg::*;

    addr_state_t    a_state;
    logic [IDW-1:0] a_owner, last_win, pick, head_id;
    logic           pick_ok, ack_window, q_push, q_pop, q_drop, can_grant;
    logic [CW-1:0]  q_count;
    logic [NM-1:0]  pick_vec, head_vec;

    arb_rr_pick #(.NM(NM), .IDW(IDW)) i_pick (
        .req      (bus_req),
        .last_win (last_win),
        .found    (pick_ok),
        .pick     (pick)
    );

    arb_tenure_fifo #(.DEPTH(QDEPTH), .W(IDW)) i_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (q_push),
        .push_id (a_owner),
        .pop     (q_pop),
        .drop    (q_drop),
        .head_id (head_id),
        .count   (q_count)
    );

    // Index-to-one-hot decode for the picked requester and the queue head.
    always_comb begin
        pick_vec = '0;
        head_vec = '0;
        pick_vec[pick]    = 1'b1;
        head_vec[head_id] = 1'b1;
    end

    // Queue control: enqueue on a clean ack, drop on a late retry, pop on grant.
    always_comb begin
        can_grant = (a_state == A_IDLE) && pick_ok && (int'(q_count) < QDEPTH);
        q_push    = (a_state == A_TENURE) && addr_ack && !addr_retry;
        q_drop    = ack_window && addr_retry;
        q_pop     = !data_busy && (q_count != '0) && !(q_drop && q_count == CW'(1));
    end

    // Address-phase state machine and round-robin history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_state    <= A_IDLE;
            a_owner    <= '0;
            last_win   <= IDW'(NM - 1);
            addr_grant <= '0;
            addr_busy  <= 1'b0;
            ack_window <= 1'b0;
        end else begin
            ack_window <= q_push;
            case (a_state)
                A_IDLE: if (can_grant) begin
                    a_state    <= A_GRANT;
                    a_owner    <= pick;
                    last_win   <= pick;
                    addr_grant <= pick_vec;
                end
                A_GRANT: if (xfer_start) begin
                    a_state    <= A_TENURE;
                    addr_grant <= '0;
                    addr_busy  <= 1'b1;
                end else if (!bus_req[a_owner]) begin
                    a_state    <= A_IDLE;
                    addr_grant <= '0;
                end
                A_TENURE: if (addr_retry || addr_ack) begin
                    a_state   <= A_IDLE;
                    addr_busy <= 1'b0;
                end
                default: begin
                    a_state    <= A_IDLE;
                    addr_grant <= '0;
                    addr_busy  <= 1'b0;
                end
            endcase
        end
    end

    // Data-phase ownership: grant the queue head, release on transfer ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_grant <= '0;
            data_busy  <= 1'b0;
        end else if (data_busy) begin
            if (xfer_ack) begin
                data_grant <= '0;
                data_busy  <= 1'b0;
            end
        end else if (q_pop) begin
            data_grant <= head_vec;
            data_busy  <= 1'b1;
        end
    end
endmodule

// File: rtl/split_bus_arbiter_chk.sv
`timescale 1ns/1ps
// Property checker for split_bus_arbiter; observes ports only.
module split_bus_arbiter_chk #(
    parameter int NM = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NM-1:0] bus_req,
    input logic [NM-1:0] addr_grant,
    input logic [NM-1:0] data_grant,
    input logic          xfer_start,
    input logic          addr_ack,
    input logic          xfer_ack,
    input logic          addr_retry,
    input logic          addr_busy,
    input logic          data_busy
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (addr_grant == '0 && data_grant == '0 && !addr_busy && !data_busy));

    // R2
    agrant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(addr_grant));

    // R2
    grant_vs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_grant != '0) |-> !addr_busy);

    // R2
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr_grant & ~$past(addr_grant)) != '0) |-> (($past(bus_req) & addr_grant) != '0));

    // R4
    abusy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_busy && !addr_ack && !addr_retry) |=> addr_busy);

    // R8
    retry_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_busy && addr_retry) |=> !addr_busy);

    // R6
    dgrant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(data_grant));

    // R6
    dbusy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_busy && !xfer_ack) |=> (data_busy && $stable(data_grant)));

    // R6
    dbusy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_busy && xfer_ack) |=> (data_grant == '0));
endmodule

bind split_bus_arbiter split_bus_arbiter_chk #(.NM(NM)) i_chk (.*);

// File: tb/test_split_bus_arbiter.sv
`timescale 1ns/1ps
// Directed bench for split_bus_arbiter: one task per scenario.
module test_split_bus_arbiter;
    localparam int NM = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NM-1:0] bus_req = '0;
    logic [NM-1:0] addr_grant, data_grant;
    logic          xfer_start = 1'b0, addr_ack = 1'b0, xfer_ack = 1'b0, addr_retry = 1'b0;
    logic          addr_busy, data_busy;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    split_bus_arbiter #(.NM(NM), .QDEPTH(2)) i_split_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req),
        .addr_grant(addr_grant), .data_grant(data_grant),
        .xfer_start(xfer_start), .addr_ack(addr_ack), .xfer_ack(xfer_ack),
        .addr_retry(addr_retry), .addr_busy(addr_busy), .data_busy(data_busy)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One address tenure for master m, ending on the negedge after the ack.
    task automatic run_addr(input int m);
        bus_req = NM'(1) << m;
        tick();
        check("R2 grant to requester", 32'(addr_grant), 32'(NM'(1) << m));
        xfer_start = 1'b1; bus_req = '0;
        tick();
        xfer_start = 1'b0; addr_ack = 1'b1;
        tick();
        addr_ack = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        check("R1 grants low in reset", 32'({addr_grant, data_grant}), 32'h0);
        rst_n = 1'b1;
        tick();
        check("R1 grants low after reset", 32'({addr_grant, data_grant}), 32'h0);
        check("R1 busy low after reset", 32'({addr_busy, data_busy}), 32'h0);
    endtask

    task automatic t_basic();
        bus_req = 4'b0010;
        check("R2 no same-cycle grant", 32'(addr_grant), 32'h0);
        tick();
        check("R2 grant next cycle", 32'(addr_grant), 32'h2);
        xfer_start = 1'b1;
        tick();
        xfer_start = 1'b0; bus_req = '0;
        check("R4 grant cleared on start", 32'(addr_grant), 32'h0);
        check("R4 addr busy set", 32'(addr_busy), 32'h1);
        tick();
        check("R4 addr busy held", 32'(addr_busy), 32'h1);
        addr_ack = 1'b1;
        tick();
        addr_ack = 1'b0;
        check("R4 addr busy released", 32'(addr_busy), 32'h0);
        check("R6 no data grant yet", 32'(data_grant), 32'h0);
        tick();
        check("R6 data grant issued", 32'(data_grant), 32'h2);
        check("R6 data busy set", 32'(data_busy), 32'h1);
        tick();
        check("R6 data grant held", 32'(data_grant), 32'h2);
        xfer_ack = 1'b1;
        tick();
        xfer_ack = 1'b0;
        check("R6 data grant released", 32'({data_grant, 3'b0, data_busy}), 32'h0);
    endtask

    task automatic t_round_robin();
        bus_req = 4'b1011;              // last winner is 1
        tick();
        check("R3 rotated winner", 32'(addr_grant), 32'h8);
        bus_req = 4'b0011;              // owner 3 withdraws
        tick();
        check("R5 grant withdrawn", 32'(addr_grant), 32'h0);
        tick();
        check("R3 wrap to master 0", 32'(addr_grant), 32'h1);
        bus_req = '0;
        tick();
        check("R5 grant withdrawn again", 32'(addr_grant), 32'h0);
    endtask

    task automatic t_queue_and_retry();
        run_addr(2);
        run_addr(0);
        run_addr(3);                    // two tenures now pending
        check("R6 first data owner", 32'(data_grant), 32'h4);
        bus_req = 4'b0010;
        tick();
        check("R7 no grant when full", 32'(addr_grant), 32'h0);
        tick();
        check("R7 still no grant", 32'(addr_grant), 32'h0);
        xfer_ack = 1'b1;
        tick();
        xfer_ack = 1'b0;
        check("R6 data released", 32'(data_grant), 32'h0);
        tick();
        check("R6 in-order data grant", 32'(data_grant), 32'h1);
        check("R7 grant blocked on pop edge", 32'(addr_grant), 32'h0);
        tick();
        check("R7 grant after slot frees", 32'(addr_grant), 32'h2);
        xfer_start = 1'b1;
        tick();
        xfer_start = 1'b0;
        check("R8 tenure open", 32'(addr_busy), 32'h1);
        addr_retry = 1'b1; addr_ack = 1'b1;
        tick();
        addr_retry = 1'b0; addr_ack = 1'b0;
        check("R8 busy released on retry", 32'(addr_busy), 32'h0);
        check("R8 no grant in release cycle", 32'(addr_grant), 32'h0);
        tick();
        check("R8 retried master re-granted", 32'(addr_grant), 32'h2);
        bus_req = '0;
        tick();
        xfer_ack = 1'b1;
        tick();
        xfer_ack = 1'b0;
        tick();
        check("R6 third data owner", 32'(data_grant), 32'h8);
        xfer_ack = 1'b1;
        tick();
        xfer_ack = 1'b0;
        tick();
        tick();
        check("R8 retried tenure never data-granted", 32'({data_grant, 3'b0, data_busy}), 32'h0);
    endtask

    task automatic t_late_retry();
        run_addr(2);
        addr_retry = 1'b1;
        tick();
        addr_retry = 1'b0;
        check("R9 no data grant after late retry", 32'(data_grant), 32'h0);
        tick();
        check("R9 data stays idle", 32'({data_grant, 3'b0, data_busy}), 32'h0);
        check("R9 addr idle", 32'(addr_busy), 32'h0);
    endtask

    task automatic t_stray();
        xfer_start = 1'b1; addr_ack = 1'b1; xfer_ack = 1'b1;
        tick();
        xfer_start = 1'b0; addr_ack = 1'b0; xfer_ack = 1'b0;
        check("R10 stray strobes ignored", 32'({addr_grant, data_grant, 2'b0, addr_busy, data_busy}), 32'h0);
        tick();
        check("R10 stray ack queued nothing", 32'({data_grant, 3'b0, data_busy}), 32'h0);
    endtask

    initial begin
        tick();
        t_reset();
        t_basic();
        t_round_robin();
        t_queue_and_retry();
        t_late_retry();
        t_stray();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule